// File: doc/BRIEF.md
# Multiplexed-Address Dynamic RAM Strobe Sequencer

This block connects an 8-bit processor's memory bus to 16-pin dynamic RAMs that take their address in two halves on one set of pins. On each memory request it captures the processor address. It puts the low half (the row) on the shared pins and pulls the row strobe low. After a programmable row-hold delay it swaps the pins to the upper half (the column) and then pulls the column strobe low. Both strobes stay low until the processor drops its request. A precharge period with both strobes high follows before the next cycle can start.

When the processor flags a refresh machine cycle, the block runs a row-strobe-only cycle. It uses the row address that the processor itself drives on the low address bits, so there is no internal refresh counter. In that cycle the column strobe and write enable stay inactive.

Write requests use early write: write enable falls one clock before the column strobe. A parameter selects the part size: 6+6 address bits (64 rows by 64 columns) or 7+7 bits (128 rows by 128 columns).

The sequencer uses these states:
- `ST_IDLE`: no cycle in progress.
- `ST_ROW`: row strobe low, row half on the pins.
- `ST_MUX`: column half on the pins.
- `ST_COL`: column strobe asserted.
- `ST_HOLD`: waiting for the request to end.
- `ST_RFSH`: refresh, row strobe only.
- `ST_PRE`: precharge.

Its transitions are:
- IDLE→ROW on an armed request without refresh.
- IDLE→RFSH on an armed request with refresh.
- ROW→MUX when the row-hold count expires.
- MUX→COL after one clock.
- COL→HOLD after one clock.
- HOLD→PRE when the request goes high.
- RFSH→PRE when the refresh count expires.
- PRE→IDLE when the precharge count expires.

A request is armed once the request input has been seen high since the previous cycle started.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After reset `ras_n`, `cas_n` and `we_n` are all 1 and no cycle starts until `mreq_n` has been sampled high.
- R2: The row half is `cpu_addr[HALF_W-1:0]` and the column half is `cpu_addr[2*HALF_W-1:HALF_W]`, where HALF_W is 7 with `ROWS_128`=1 and 6 otherwise. Both halves appear on `dram_addr`.
- R3: On the first rising edge in idle at which an armed `mreq_n`=0 and `rfsh_n`=1 are sampled, `ras_n` goes to 0 and `dram_addr` carries the row half.
- R4: `dram_addr` switches to the column half exactly ROW_HOLD clocks after `ras_n` falls, and `cas_n` falls one clock after that. `cas_n` is never 0 while `ras_n` is 1.
- R5: `ras_n` and `cas_n` stay at 0, and `dram_addr` stays stable, while `mreq_n` stays 0. On the first edge that samples `mreq_n`=1, both strobes and `we_n` return to 1.
- R6: Between two cycles `ras_n` stays high for at least PRECHARGE_CLKS+1 clocks. With back-to-back requests it stays high exactly that long.
- R7: An armed request with `rfsh_n`=0 drives `ras_n` low for exactly REFRESH_CLKS clocks, with the row half of `cpu_addr` on `dram_addr`. `cas_n` and `we_n` stay 1 throughout, even with `wr_n`=0.
- R8: If `wr_n`=0 when the cycle starts, `we_n` goes to 0 on the same edge the pins switch to the column half, which is one clock before `cas_n` falls. If `wr_n`=1, `we_n` stays 1.
- R9: A request held low past the end of its cycle does not start a second cycle; `mreq_n` must be sampled high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mreq_n | input | 1 | Processor memory request, active low |
| rfsh_n | input | 1 | Processor refresh cycle flag, active low |
| wr_n | input | 1 | Processor write request, active low |
| cpu_addr | input | 2*HALF_W | Processor address |
| dram_addr | output | HALF_W | Multiplexed row/column address pins |
| ras_n | output | 1 | Row strobe, active low, registered |
| cas_n | output | 1 | Column strobe, active low, registered |
| we_n | output | 1 | Write enable, active low, registered |

## Verification
The hardest case to reach is a request that stays low after its cycle ends: refresh finishes on its own count, so the same request would retrigger if arming were wrong. The refresh scenario holds `mreq_n` low for many clocks past the refresh count and watches `ras_n` stay high. A back-to-back scenario reissues a request on the very clock after release, so the precharge gap is measured at its minimum.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_MUX,
        ST_COL,
        ST_HOLD,
        ST_RFSH,
        ST_PRE
    } seq_state_e;

    function automatic int half_width(input bit rows_128);
        return rows_128 ? 7 : 6;
    endfunction

endpackage

// File: rtl/dram_delay_cnt.sv
module dram_delay_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
    parameter int HALF_W = 7,
    localparam int ADDR_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              track,
    input  logic              sel_col,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [HALF_W-1:0] pins
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (capture)
            addr_q <= cpu_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pins <= '0;
        else if (sel_col)
            pins <= addr_q[ADDR_W-1:HALF_W];
        else if (track)
            pins <= cpu_addr[HALF_W-1:0];
        else
            pins <= addr_q[HALF_W-1:0];
    end
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
    import dram_seq_pkg::*;
#(
    parameter bit ROWS_128       = 1'b1,
    parameter int ROW_HOLD       = 2,
    parameter int REFRESH_CLKS   = 3,
    parameter int PRECHARGE_CLKS = 2,
    localparam int HALF_W = half_width(ROWS_128),
    localparam int ADDR_W = 2 * HALF_W,
    localparam int MAX_T  = (ROW_HOLD > REFRESH_CLKS)
                            ? ((ROW_HOLD > PRECHARGE_CLKS) ? ROW_HOLD : PRECHARGE_CLKS)
                            : ((REFRESH_CLKS > PRECHARGE_CLKS) ? REFRESH_CLKS : PRECHARGE_CLKS),
    localparam int CNT_W  = $clog2(MAX_T + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreq_n,
    input  logic              rfsh_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [HALF_W-1:0] dram_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n
);
    seq_state_e       state_q, state_d;
    logic             armed_q;
    logic             wr_q;
    logic             start;
    logic             tmr_load;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;

    assign start = (state_q == ST_IDLE) && !mreq_n && armed_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = rfsh_n ? ST_ROW : ST_RFSH;
            ST_ROW:  if (tmr_done) state_d = ST_MUX;
            ST_MUX:  state_d = ST_COL;
            ST_COL:  state_d = ST_HOLD;
            ST_HOLD: if (mreq_n) state_d = ST_PRE;
            ST_RFSH: if (tmr_done) state_d = ST_PRE;
            ST_PRE:  if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_d != state_q) &&
                      (state_d inside {ST_ROW, ST_RFSH, ST_PRE});

    always_comb begin
        unique case (state_d)
            ST_ROW:  tmr_val = CNT_W'(ROW_HOLD - 1);
            ST_RFSH: tmr_val = CNT_W'(REFRESH_CLKS - 1);
            default: tmr_val = CNT_W'(PRECHARGE_CLKS - 1);
        endcase
    end

    dram_delay_cnt #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    dram_addr_mux #(.HALF_W(HALF_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (start),
        .track    (state_q == ST_IDLE),
        .sel_col  (state_d inside {ST_MUX, ST_COL, ST_HOLD}),
        .cpu_addr (cpu_addr),
        .pins     (dram_addr)
    );

    // state register and request bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            armed_q <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start)
                armed_q <= 1'b0;
            else if (mreq_n)
                armed_q <= 1'b1;
            if (start)
                wr_q <= !wr_n && rfsh_n;
        end
    end

    // registered strobe outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
        end else begin
            ras_n <= !(state_d inside {ST_ROW, ST_MUX, ST_COL, ST_HOLD, ST_RFSH});
            cas_n <= !(state_d inside {ST_COL, ST_HOLD});
            we_n  <= !(wr_q && (state_d inside {ST_MUX, ST_COL, ST_HOLD}));
        end
    end
endmodule

// File: rtl/dram_strobe_chk.sv
module dram_strobe_chk
    import dram_seq_pkg::*;
#(
    parameter int HALF_W         = 7,
    parameter int PRECHARGE_CLKS = 2,
    localparam int GAP_W = $clog2(PRECHARGE_CLKS + 2) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [HALF_W-1:0] dram_addr,
    input seq_state_e        st
);
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (!ras_n) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q < GAP_W'(PRECHARGE_CLKS + 1)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R4
    cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R4
    cas_after_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(!ras_n));

    // R5
    col_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));

    // R6
    precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && seen_q) |-> (gap_q >= GAP_W'(PRECHARGE_CLKS + 1)));

    // R7
    refresh_no_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RFSH) |=> (cas_n && we_n));

    // R8
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> cas_n);
endmodule

bind dram_strobe_ctrl dram_strobe_chk #(
    .HALF_W         (HALF_W),
    .PRECHARGE_CLKS (PRECHARGE_CLKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dram_addr (dram_addr),
    .st        (state_q)
);

// File: tb/dram_strobe_ctrl_test.sv
module dram_strobe_ctrl_test;
    localparam int HW    = 7;
    localparam int AW    = 2 * HW;
    localparam int RHOLD = 2;
    localparam int RFCLK = 3;
    localparam int PRE   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mreq_n = 1'b1;
    logic          rfsh_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] cpu_addr = '0;
    logic [HW-1:0] dram_addr;
    logic          ras_n, cas_n, we_n;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dram_strobe_ctrl #(
        .ROWS_128(1'b1), .ROW_HOLD(RHOLD),
        .REFRESH_CLKS(RFCLK), .PRECHARGE_CLKS(PRE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .rfsh_n(rfsh_n),
        .wr_n(wr_n), .cpu_addr(cpu_addr), .dram_addr(dram_addr),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        step();
        check({ras_n, cas_n, we_n} == 3'b111, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
        rst_n = 1'b1;
        step();
        step();
        check(ras_n == 1'b1, "R1 no cycle without request", ras_n, 1);
    endtask

    // full access; leaves mreq_n high on return at the release negedge + 1
    task automatic t_access(input logic [AW-1:0] a, input bit wr, input bit back2back);
        cpu_addr = a;
        wr_n = !wr;
        mreq_n = 1'b0;
        step();
        check(ras_n == 1'b0, "R3 ras falls on first edge", ras_n, 0);
        check(dram_addr == a[HW-1:0], "R2 R3 row half on pins", dram_addr, a[HW-1:0]);
        for (int i = 1; i < RHOLD; i++) begin
            step();
            check(dram_addr == a[HW-1:0] && cas_n, "R4 row held", dram_addr, a[HW-1:0]);
        end
        step();
        check(dram_addr == a[AW-1:HW], "R2 R4 column half after row hold", dram_addr, a[AW-1:HW]);
        check(cas_n == 1'b1, "R4 cas still high at switch", cas_n, 1);
        check(we_n == !wr, "R8 we_n at switch", we_n, !wr);
        step();
        check(cas_n == 1'b0 && ras_n == 1'b0, "R4 cas falls next clock", {ras_n, cas_n}, 0);
        for (int i = 0; i < 3; i++) begin
            step();
            check({ras_n, cas_n} == 2'b00 && dram_addr == a[AW-1:HW],
                  "R5 held while request low", {ras_n, cas_n, dram_addr}, a[AW-1:HW]);
            check(we_n == !wr, "R8 R9 we_n during hold", we_n, !wr);
        end
        mreq_n = 1'b1;
        wr_n = 1'b1;
        step();
        check({ras_n, cas_n, we_n} == 3'b111, "R5 strobes rise on release", {ras_n, cas_n, we_n}, 7);
        if (back2back) begin
            int gap;
            gap = 1;
            mreq_n = 1'b0;
            cpu_addr = ~a;
            while (ras_n && gap < 20) begin
                step();
                if (ras_n) gap++;
            end
            check(gap == PRE + 1, "R6 minimum precharge gap", gap, PRE + 1);
            mreq_n = 1'b1;
            while (!ras_n) step();
            for (int i = 0; i < PRE + 1; i++) step();
        end else begin
            for (int i = 0; i < PRE + 1; i++) step();
        end
    endtask

    task automatic t_refresh(input logic [AW-1:0] a);
        int low;
        cpu_addr = a;
        rfsh_n = 1'b0;
        wr_n = 1'b0;
        mreq_n = 1'b0;
        step();
        check(ras_n == 1'b0 && dram_addr == a[HW-1:0], "R7 refresh row on pins", dram_addr, a[HW-1:0]);
        low = 0;
        for (int i = 0; i < 12; i++) begin
            if (!ras_n) low++;
            check(cas_n == 1'b1 && we_n == 1'b1, "R7 no cas or we in refresh", {cas_n, we_n}, 3);
            step();
        end
        check(low == RFCLK, "R7 refresh length", low, RFCLK);
        check(ras_n == 1'b1, "R9 held request does not retrigger", ras_n, 1);
        mreq_n = 1'b1;
        rfsh_n = 1'b1;
        wr_n = 1'b1;
        step();
        step();
    endtask

    initial begin
        t_reset();
        t_access(14'h2A5B, 1'b0, 1'b0);
        t_access(14'h1F80, 1'b1, 1'b0);
        t_refresh(14'h3FC5);
        t_access(14'h007F, 1'b1, 1'b1);
        t_access(14'h3F00, 1'b0, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule